// File: doc/BRIEF.md
# Asynchronous Serial Port with Selectable Bit-Rate Sources

This block is a full-duplex asynchronous serial port. Each frame has ten bits: a low start bit, eight data bits sent least significant bit first, and a high stop bit. The bit timing of each direction comes from one of two overflow strobes, A and B, which timers elsewhere on the chip supply. Strobe A passes through a divide-by-2 unless `a_nodiv_i` is set. The transmitter and the receiver each choose A or B on their own. Every bit lasts sixteen pulses of the chosen strobe.

The transmitter starts a frame when software writes a byte. The frame begins on the next sixteen-pulse boundary, and `tx_done_o` rises when the stop bit starts. The receiver runs only when `rx_enable_i` is high. It waits for a falling edge on `rxd_i` and takes three samples around the middle of each bit, keeping the majority value. If the start bit reads high, the receiver treats it as noise and returns to idle. At the middle of the stop bit it loads the byte into the receive buffer, copies the stop bit into `stop_flag_o` and raises `rx_full_o`. It does this only if `rx_full_o` was clear; otherwise it drops the frame. Software clears both flags with their clear strobes.

The transmitter has the states TX_IDLE, TX_START, TX_DATA and TX_STOP. Its transitions are:
- TX_IDLE to TX_START on a boundary with a byte pending.
- TX_START to TX_DATA on the next boundary.
- TX_DATA to TX_STOP on the boundary after the eighth data bit.
- TX_STOP to TX_IDLE on the next boundary.

The receiver has the states RX_IDLE, RX_START, RX_DATA and RX_STOP. Its transitions are:
- RX_IDLE to RX_START on a falling edge while enabled.
- RX_START back to RX_IDLE when the start-bit majority is high.
- RX_START to RX_DATA at the end of the start bit.
- RX_DATA to RX_STOP at the end of the eighth data bit.
- RX_STOP to RX_IDLE at the stop-bit decision.

Top module: `async_serial_port`

## Requirements
- R1: `txd_o` idles at 1. A frame drives 0 for one bit, then data bits 0 to 7 in order, then 1 for one bit. Each bit lasts 16 pulses of the transmit source.
- R2: With `tx_use_b_i`=1 the transmit source is strobe B. With it at 0 the source is strobe A after its divider.
- R3: With `a_nodiv_i`=0 only every second A pulse counts, so bits are twice as long. With `a_nodiv_i`=1 every A pulse counts.
- R4: The receive source is chosen by `rx_use_b_i` (1 = B, 0 = divided A), independently of the transmit choice.
- R5: A write when the transmitter is idle starts the start bit at the next 16-pulse boundary, within one bit time. A write while a frame is pending or in progress is ignored.
- R6: `tx_done_o` rises at the same edge at which the stop bit begins. It stays high until `tx_done_clr_i`.
- R7: The receiver starts on a 1-to-0 transition of `rxd_i` only while `rx_enable_i`=1. With `rx_enable_i`=0 a whole frame leaves all receive outputs unchanged.
- R8: Each bit value is the majority of samples at pulses 7, 8 and 9 of the bit. A start bit whose majority is 1 makes the receiver abandon the frame, leaving the outputs unchanged.
- R9: At the end of a frame with `rx_full_o`=0, the receive buffer gets the data bits (first bit = bit 0), `stop_flag_o` gets the stop-bit value, and `rx_full_o` is set.
- R10: At the end of a frame with `rx_full_o`=1, the frame is discarded. The buffer and `stop_flag_o` keep their values.
- R11: After reset `txd_o`=1 and `tx_done_o`=0, `rx_full_o`=0, `stop_flag_o`=0 and `rx_data_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovf_a_i | input | 1 | Overflow strobe A (divisible by 2) |
| ovf_b_i | input | 1 | Overflow strobe B |
| a_nodiv_i | input | 1 | 1 = bypass the divide-by-2 on strobe A |
| tx_use_b_i | input | 1 | 1 = transmitter uses strobe B |
| rx_use_b_i | input | 1 | 1 = receiver uses strobe B |
| tx_wr_i | input | 1 | Write strobe for the transmit byte |
| tx_data_i | input | 8 | Byte to transmit |
| tx_done_clr_i | input | 1 | Clears `tx_done_o` |
| txd_o | output | 1 | Serial transmit line |
| tx_done_o | output | 1 | Stop bit has started |
| rxd_i | input | 1 | Serial receive line (asynchronous) |
| rx_enable_i | input | 1 | Allows reception |
| rx_full_clr_i | input | 1 | Clears `rx_full_o` |
| rx_full_o | output | 1 | Receive buffer holds a new byte |
| stop_flag_o | output | 1 | Stop-bit value of the last accepted frame |
| rx_data_o | output | 8 | Receive buffer |

## Verification
If the transmit bit index or divider is off, the fault shows on `txd_o` within the same frame. The line would fall late, shift a bit, or enter the stop level one bit early, and `tx_done_o` would move with it. If the receive state is wrong, the fault shows only at the stop-bit decision, about 9.5 bit times after the start edge. It appears as a wrong byte, a wrong stop flag, or a missing or unwanted `rx_full_o`. A glitch that is not rejected shows as a spurious frame within one frame time. The divider and source selects show as bit periods of 64 or 128 cycles, measured on the line.

// File: rtl/serial_pkg.sv
package serial_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/serial_rate_sel.sv
module serial_rate_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_a_i,
    input  logic ovf_b_i,
    input  logic a_nodiv_i,
    input  logic tx_use_b_i,
    input  logic rx_use_b_i,
    output logic tx_tick_o,
    output logic rx_tick_o
);
    logic half_q;
    logic a_eff;

    // toggles on every A strobe; gates every second one when dividing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       half_q <= 1'b0;
        else if (ovf_a_i) half_q <= ~half_q;
    end

    assign a_eff     = ovf_a_i & (a_nodiv_i | half_q);
    assign tx_tick_o = tx_use_b_i ? ovf_b_i : a_eff;
    assign rx_tick_o = rx_use_b_i ? ovf_b_i : a_eff;
endmodule

// File: rtl/serial_tx.sv
module serial_tx
    import serial_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              done_clr_i,
    output logic              txd_o,
    output logic              done_o,
    output logic              bound_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  div_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sh_q;
    logic              pend_q;
    logic              last_bit;
    logic              accept;

    assign bound_o  = tick_i && (div_q == CNT_W'(OVS - 1));
    assign last_bit = (idx_q == IDX_W'(DATA_W - 1));
    assign accept   = wr_i && (state_q == TX_IDLE) && !pend_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (bound_o && pend_q)   state_d = TX_START;
            TX_START: if (bound_o)             state_d = TX_DATA;
            TX_DATA:  if (bound_o && last_bit) state_d = TX_STOP;
            TX_STOP:  if (bound_o)             state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
            pend_q <= 1'b0;
            txd_o  <= 1'b1;
            done_o <= 1'b0;
        end else begin
            if (tick_i) div_q <= div_q + 1'b1;
            if (accept) begin
                sh_q   <= data_i;
                pend_q <= 1'b1;
            end
            unique case (state_q)
                TX_IDLE: if (state_d == TX_START) begin
                    txd_o  <= 1'b0;
                    pend_q <= 1'b0;
                end
                TX_START: if (bound_o) begin
                    txd_o <= sh_q[0];
                    sh_q  <= sh_q >> 1;
                    idx_q <= '0;
                end
                TX_DATA: if (bound_o) begin
                    if (last_bit) begin
                        txd_o <= 1'b1;
                    end else begin
                        txd_o <= sh_q[0];
                        sh_q  <= sh_q >> 1;
                        idx_q <= idx_q + 1'b1;
                    end
                end
                TX_STOP: ;
            endcase
            if (state_q == TX_DATA && state_d == TX_STOP) done_o <= 1'b1;
            else if (done_clr_i)                          done_o <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rxd_i,
    input  logic              en_i,
    input  logic              full_clr_i,
    output logic              full_o,
    output logic              stop_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int MID   = OVS / 2;

    rx_state_e         state_q, state_d;
    logic [1:0]        sync_q;
    logic              prev_q;
    logic              rx_s;
    logic              fall;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [1:0]        smp_q;
    logic [DATA_W-1:0] sh_q;
    logic              at_s0, at_s1, at_dec, at_end;
    logic              maj;
    logic              last_bit;

    assign rx_s     = sync_q[1];
    assign fall     = prev_q & ~rx_s;
    assign at_s0    = tick_i && (cnt_q == CNT_W'(MID - 1));
    assign at_s1    = tick_i && (cnt_q == CNT_W'(MID));
    assign at_dec   = tick_i && (cnt_q == CNT_W'(MID + 1));
    assign at_end   = tick_i && (cnt_q == CNT_W'(OVS - 1));
    assign maj      = (smp_q[0] & smp_q[1]) | (smp_q[0] & rx_s) | (smp_q[1] & rx_s);
    assign last_bit = (idx_q == IDX_W'(DATA_W - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (en_i && fall)       state_d = RX_START;
            RX_START: if (at_dec && maj)      state_d = RX_IDLE;
                      else if (at_end)        state_d = RX_DATA;
            RX_DATA:  if (at_end && last_bit) state_d = RX_STOP;
            RX_STOP:  if (at_dec)             state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            prev_q <= 1'b1;
            cnt_q  <= '0;
            idx_q  <= '0;
            smp_q  <= '0;
            sh_q   <= '0;
            full_o <= 1'b0;
            stop_o <= 1'b0;
            data_o <= '0;
        end else begin
            sync_q <= {sync_q[0], rxd_i};
            prev_q <= rx_s;
            if (state_q == RX_IDLE) cnt_q <= '0;
            else if (tick_i)        cnt_q <= cnt_q + 1'b1;
            if (at_s0) smp_q[0] <= rx_s;
            if (at_s1) smp_q[1] <= rx_s;
            unique case (state_q)
                RX_IDLE: ;
                RX_START: if (state_d == RX_DATA) idx_q <= '0;
                RX_DATA: begin
                    if (at_dec) sh_q <= {maj, sh_q[DATA_W-1:1]};
                    if (at_end) idx_q <= idx_q + 1'b1;
                end
                RX_STOP: ;
            endcase
            if (state_q == RX_STOP && at_dec && !full_o) begin
                data_o <= sh_q;
                stop_o <= maj;
                full_o <= 1'b1;
            end else if (full_clr_i) begin
                full_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovf_a_i,
    input  logic              ovf_b_i,
    input  logic              a_nodiv_i,
    input  logic              tx_use_b_i,
    input  logic              rx_use_b_i,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_done_clr_i,
    output logic              txd_o,
    output logic              tx_done_o,
    input  logic              rxd_i,
    input  logic              rx_enable_i,
    input  logic              rx_full_clr_i,
    output logic              rx_full_o,
    output logic              stop_flag_o,
    output logic [DATA_W-1:0] rx_data_o
);
    logic tx_tick;
    logic rx_tick;
    logic tx_bound;

    serial_rate_sel u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_a_i    (ovf_a_i),
        .ovf_b_i    (ovf_b_i),
        .a_nodiv_i  (a_nodiv_i),
        .tx_use_b_i (tx_use_b_i),
        .rx_use_b_i (rx_use_b_i),
        .tx_tick_o  (tx_tick),
        .rx_tick_o  (rx_tick)
    );

    serial_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tx_tick),
        .wr_i       (tx_wr_i),
        .data_i     (tx_data_i),
        .done_clr_i (tx_done_clr_i),
        .txd_o      (txd_o),
        .done_o     (tx_done_o),
        .bound_o    (tx_bound)
    );

    serial_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (rx_tick),
        .rxd_i      (rxd_i),
        .en_i       (rx_enable_i),
        .full_clr_i (rx_full_clr_i),
        .full_o     (rx_full_o),
        .stop_o     (stop_flag_o),
        .data_o     (rx_data_o)
    );
endmodule

// File: rtl/serial_port_chk.sv
module serial_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txd,
    input logic              tx_done,
    input logic              tx_bound,
    input logic              tx_tick,
    input logic              a_nodiv,
    input logic              tx_use_b,
    input logic              rx_full,
    input logic              rx_full_clr,
    input logic              stop_flag,
    input logic [DATA_W-1:0] rx_data
);
    // R6: the done flag rises only together with the stop level
    p_done_on_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> txd);

    // R5: a frame begins only on a bit boundary
    p_start_on_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> $past(tx_bound));

    // R10: a held buffer does not change until released
    p_hold_buffer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_full_clr) |=> (rx_full && $stable(rx_data) && $stable(stop_flag)));

    // R3: with the divider active, two A-derived pulses never come back to back
    p_half_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_tick && !a_nodiv && !tx_use_b) |=> (!tx_tick || a_nodiv || tx_use_b));
endmodule

bind async_serial_port serial_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .txd         (txd_o),
    .tx_done     (tx_done_o),
    .tx_bound    (tx_bound),
    .tx_tick     (tx_tick),
    .a_nodiv     (a_nodiv_i),
    .tx_use_b    (tx_use_b_i),
    .rx_full     (rx_full_o),
    .rx_full_clr (rx_full_clr_i),
    .stop_flag   (stop_flag_o),
    .rx_data     (rx_data_o)
);

// File: tb/async_serial_port_bench.sv
`timescale 1ns/1ps
module async_serial_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ovf_a = 1'b0, ovf_b = 1'b0;
    logic       a_nodiv = 1'b0, tx_use_b = 1'b1, rx_use_b = 1'b1;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_done_clr = 1'b0;
    logic       txd, tx_done;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic       rx_full_clr = 1'b0;
    logic       rx_full, stop_flag;
    logic [7:0] rx_data;
    int         checks = 0;
    int         errors = 0;

    // each entry: {stop bit, data byte}
    localparam logic [8:0] RX_VEC [8] = '{9'h1A5, 9'h100, 9'h1FF, 9'h03C,
                                          9'h181, 9'h17E, 9'h055, 9'h1C3};

    always #2.5 clk = ~clk;

    async_serial_port u_async_serial_port (
        .clk(clk), .rst_n(rst_n), .ovf_a_i(ovf_a), .ovf_b_i(ovf_b),
        .a_nodiv_i(a_nodiv), .tx_use_b_i(tx_use_b), .rx_use_b_i(rx_use_b),
        .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_done_clr_i(tx_done_clr),
        .txd_o(txd), .tx_done_o(tx_done), .rxd_i(rxd), .rx_enable_i(rx_en),
        .rx_full_clr_i(rx_full_clr), .rx_full_o(rx_full),
        .stop_flag_o(stop_flag), .rx_data_o(rx_data)
    );

    // overflow strobes: A and B each once every 4 cycles, offset
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            ovf_a = (k % 4 == 0);
            ovf_b = (k % 4 == 2);
            k++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_rx(input logic [7:0] d, input logic stop, input int bitlen);
        @(negedge clk); rxd = 1'b0;
        repeat (bitlen) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (bitlen) @(negedge clk);
        end
        rxd = stop;
        repeat (bitlen) @(negedge clk);
        rxd = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic clear_full();
        @(negedge clk); rx_full_clr = 1'b1;
        @(negedge clk); rx_full_clr = 1'b0;
    endtask

    // writes a byte and checks the frame on txd; optional second write during the start bit
    task automatic send_tx(input logic [7:0] d, input int bitlen, input string req,
                           input bit busy_wr);
        int wait_n = 0;
        @(negedge clk); tx_wr = 1'b1; tx_data = d;
        @(negedge clk); tx_wr = 1'b0; tx_data = ~d;
        while (txd === 1'b1 && wait_n < 4 * bitlen) begin
            @(negedge clk); wait_n++;
        end
        chk("R5", "start latency within one bit", 32'(wait_n <= bitlen + 2), 32'd1);
        repeat (bitlen / 2) @(negedge clk);
        chk(req, "start bit", 32'(txd), 32'd0);
        if (busy_wr) begin
            tx_wr = 1'b1; tx_data = 8'h5A;
            @(negedge clk); tx_wr = 1'b0;
            repeat (bitlen - 1) @(negedge clk);
        end else begin
            repeat (bitlen) @(negedge clk);
        end
        for (int i = 0; i < 8; i++) begin
            chk(req, $sformatf("data bit %0d", i), 32'(txd), 32'(d[i]));
            if (i == 7) chk("R6", "done low before stop", 32'(tx_done), 32'd0);
            repeat (bitlen) @(negedge clk);
        end
        chk(req, "stop bit", 32'(txd), 32'd1);
        chk("R6", "done set in stop bit", 32'(tx_done), 32'd1);
        repeat (bitlen) @(negedge clk);
        @(negedge clk); tx_done_clr = 1'b1;
        @(negedge clk); tx_done_clr = 1'b0;
        chk("R6", "done cleared", 32'(tx_done), 32'd0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R11: reset state
        chk("R11", "txd", 32'(txd), 32'd1);
        chk("R11", "tx_done", 32'(tx_done), 32'd0);
        chk("R11", "rx_full", 32'(rx_full), 32'd0);
        chk("R11", "stop_flag", 32'(stop_flag), 32'd0);
        chk("R11", "rx_data", 32'(rx_data), 32'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1", "idle line high", 32'(txd), 32'd1);

        // R9: table of received frames on source B (64-cycle bits)
        for (int v = 0; v < 8; v++) begin
            send_rx(RX_VEC[v][7:0], RX_VEC[v][8], 64);
            chk("R9", "full set", 32'(rx_full), 32'd1);
            chk("R9", "buffer", 32'(rx_data), 32'(RX_VEC[v][7:0]));
            chk("R9", "stop flag", 32'(stop_flag), 32'(RX_VEC[v][8]));
            clear_full();
        end

        // R1/R2: transmit on strobe B
        tx_use_b = 1'b1;
        send_tx(8'hA5, 64, "R1", 1'b0);
        send_tx(8'h01, 64, "R2", 1'b0);
        // R3: strobe A divided by 2 -> 128-cycle bits; undivided -> 64
        tx_use_b = 1'b0; a_nodiv = 1'b0;
        send_tx(8'h80, 128, "R3", 1'b0);
        a_nodiv = 1'b1;
        send_tx(8'h3C, 64, "R3", 1'b0);

        // R5: write during a frame is ignored, no second frame follows
        tx_use_b = 1'b1;
        send_tx(8'hC6, 64, "R5", 1'b1);
        begin
            int lows = 0;
            for (int i = 0; i < 3 * 64 * 16; i++) begin
                @(negedge clk);
                if (txd !== 1'b1) lows++;
            end
            chk("R5", "no frame from busy write", 32'(lows), 32'd0);
        end

        // R4: receiver on divided A (128-cycle bits) while transmitter stays on B
        rx_use_b = 1'b0; a_nodiv = 1'b0;
        send_rx(8'h96, 1'b1, 128);
        chk("R4", "buffer on A source", 32'(rx_data), 32'h96);
        chk("R4", "full on A source", 32'(rx_full), 32'd1);
        clear_full();
        rx_use_b = 1'b1;

        // R8: short low pulse is rejected as a false start
        @(negedge clk); rxd = 1'b0;
        repeat (8) @(negedge clk); rxd = 1'b1;
        repeat (1200) @(negedge clk);
        chk("R8", "glitch sets no flag", 32'(rx_full), 32'd0);
        chk("R8", "glitch leaves buffer", 32'(rx_data), 32'h96);
        // R8: a single-sample glitch mid-bit is outvoted
        @(negedge clk); rxd = 1'b0;
        repeat (64) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = 1'b1;
            repeat (30) @(negedge clk);
            if (i == 2) rxd = 1'b0;
            repeat (4) @(negedge clk);
            rxd = 1'b1;
            repeat (30) @(negedge clk);
        end
        repeat (64 + 20) @(negedge clk);
        chk("R8", "majority outvotes one bad sample", 32'(rx_data), 32'hFF);
        clear_full();

        // R7: reception disabled
        rx_en = 1'b0;
        send_rx(8'h11, 1'b1, 64);
        chk("R7", "disabled full", 32'(rx_full), 32'd0);
        chk("R7", "disabled buffer", 32'(rx_data), 32'hFF);
        rx_en = 1'b1;

        // R10: buffer held while full
        send_rx(8'h42, 1'b1, 64);
        chk("R10", "first byte taken", 32'(rx_data), 32'h42);
        send_rx(8'h24, 1'b0, 64);
        chk("R10", "overrun buffer kept", 32'(rx_data), 32'h42);
        chk("R10", "overrun stop flag kept", 32'(stop_flag), 32'd1);
        chk("R10", "full still set", 32'(rx_full), 32'd1);
        clear_full();
        chk("R10", "full cleared", 32'(rx_full), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule